// File: doc/BRIEF.md
# Time-Multiplexed Leaky Integrate-and-Fire Layer with Hard Winner-Take-All

This block models a layer of spiking neurons. All of them share one arithmetic datapath and keep their membrane states in a small register bank. A pulse on the step input starts one time step, nominally one millisecond. The block then presents the neurons to the outside one per clock cycle, in ascending index order. For the neuron on `nidx_o`, the surrounding logic returns two values in the same cycle: the summed synaptic current of the inputs that are currently active, on `cur_i`, and that neuron's firing threshold, on `thr_i`.

For each presented neuron the block applies a first-order leak with a time constant of about 128 steps. It then adds the current and compares the result with the threshold. When the state reaches the threshold, the neuron emits a one-cycle spike strobe that carries its index, and its state restarts from zero.

A spike also enforces a hard winner-take-all. Every other neuron is cleared and held at zero for the rest of that step and for a fixed number of following steps. Only the winner keeps integrating during that window. Weight adaptation and threshold adaptation belong to the surrounding logic.

Top module: `lif_layer`

## Requirements
- R1: After reset no neuron fires and the block is idle, and every state is zero: with zero current and a threshold of 1, a step produces no spike.
- R2: A `step_i` pulse while idle makes `busy_o` high from the next cycle for exactly N_NEUR cycles. During those cycles `nidx_o` runs 0, 1, ..., N_NEUR-1, one index per cycle.
- R3: A neuron that is not inhibited is updated as X <- X - (X >> 7) + I in unsigned arithmetic, where I is `cur_i` sampled while `nidx_o` shows that neuron.
- R4: A neuron fires when its updated state is greater than or equal to `thr_i`. On the cycle after the neuron is presented, `spike_o` is high for one cycle and `spike_idx_o` shows its index. The neuron's state then becomes zero.
- R5: At most one neuron fires per step. If several would cross in the same step, only the lowest index fires.
- R6: After a spike in step s, every other neuron has state zero and cannot fire during the rest of step s and during steps s+1 to s+10. It resumes integrating from zero in step s+11.
- R7: The winner is not inhibited. It integrates from zero in the following steps, may fire again inside the window, and each new spike restarts the window.
- R8: A `step_i` pulse that arrives while `busy_o` is high is ignored. The sweep still ends after N_NEUR cycles and no second sweep follows.
- R9: The state is 16 bits and saturates at 65535 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Starts one time step when the block is idle |
| busy_o | output | 1 | High while the neurons are being swept |
| nidx_o | output | IDXW | Index of the neuron presented this cycle |
| cur_i | input | IW | Summed active-synapse current for neuron `nidx_o` |
| thr_i | input | XW | Threshold of neuron `nidx_o` |
| spike_o | output | 1 | One-cycle spike strobe |
| spike_idx_o | output | IDXW | Index of the neuron that fired |

## Verification
The main function is driven in several ways: with no current; with a single active neuron whose crossing step follows from the leak arithmetic; with two equal currents that cross in the same step; and with a strong neuron next to a weak one. These cases separate, in turn, integration, lowest-index arbitration, winner refiring and the end of the inhibition window. A state that lands exactly on its threshold checks that the comparison is inclusive. A current large enough to overflow the state on the second step is seen as a spike only when saturation is present, because a wrapped sum would stay below the threshold.

// File: rtl/lif_pkg.sv
package lif_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/lif_seq.sv
module lif_seq #(
    parameter int N_NEUR = 8,
    parameter int IDXW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    output logic            busy_o,
    output logic [IDXW-1:0] idx_o,
    output logic            last_o
);
    import lif_pkg::*;

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(N_NEUR - 1);

    typedef struct packed {
        seq_state_e      st;
        logic [IDXW-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SEQ_IDLE: begin
                if (step_i) begin
                    s_d.st  = SEQ_RUN;
                    s_d.idx = '0;
                end
            end
            default: begin
                if (s_q.idx == LAST_IDX) begin
                    s_d.st = SEQ_IDLE;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, idx: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.st == SEQ_RUN);
    assign idx_o  = s_q.idx;
    assign last_o = busy_o && (s_q.idx == LAST_IDX);
endmodule

// File: rtl/lif_inhibit.sv
module lif_inhibit #(
    parameter int N_NEUR    = 8,
    parameter int IDXW      = 3,
    parameter int INH_STEPS = 10,
    parameter int INHW      = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire_i,
    input  logic [IDXW-1:0] fire_idx_i,
    input  logic            step_end_i,
    output logic            inh_o,
    output logic [IDXW-1:0] win_o
);
    // The window counts the steps still held, including the current one.
    localparam logic [INHW-1:0] ARM = INHW'(INH_STEPS + 1);

    typedef struct packed {
        logic [INHW-1:0] left;
        logic [IDXW-1:0] win;
    } inh_t;

    inh_t h_d, h_q;
    logic [INHW-1:0] base;

    always_comb begin
        h_d  = h_q;
        base = h_q.left;
        if (fire_i) begin
            base    = ARM;
            h_d.win = fire_idx_i;
        end
        if (step_end_i && base != '0) begin
            h_d.left = base - 1'b1;
        end else begin
            h_d.left = base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign inh_o = (h_q.left != '0);
    assign win_o = h_q.win;
endmodule

// File: rtl/lif_leak.sv
module lif_leak #(
    parameter int XW    = 16,
    parameter int IW    = 16,
    parameter int SHIFT = 7
) (
    input  logic [XW-1:0] x_i,
    input  logic [IW-1:0] cur_i,
    output logic [XW-1:0] x_o
);
    localparam int SW = ((XW > IW) ? XW : IW) + 1;
    localparam logic [SW-1:0] XMAX = SW'({XW{1'b1}});

    logic [XW-1:0] leaked;
    logic [SW-1:0] sum;

    always_comb begin
        leaked = x_i - (x_i >> SHIFT);
        sum    = SW'(leaked) + SW'(cur_i);
        if (sum > XMAX) begin
            x_o = {XW{1'b1}};
        end else begin
            x_o = sum[XW-1:0];
        end
    end
endmodule

// File: rtl/lif_state_bank.sv
module lif_state_bank #(
    parameter int N_NEUR = 8,
    parameter int IDXW   = 3,
    parameter int XW     = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [IDXW-1:0] addr_i,
    input  logic [XW-1:0]   wdata_i,
    output logic [XW-1:0]   rdata_o
);
    logic [XW-1:0] mem_q [N_NEUR];

    for (genvar g = 0; g < N_NEUR; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (we_i && addr_i == IDXW'(g)) begin
                mem_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/lif_layer.sv
module lif_layer #(
    parameter int N_NEUR     = 8,
    parameter int XW         = 16,
    parameter int IW         = 16,
    parameter int LEAK_SHIFT = 7,
    parameter int INH_STEPS  = 10,
    parameter int IDXW       = (N_NEUR > 1) ? $clog2(N_NEUR) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    output logic            busy_o,
    output logic [IDXW-1:0] nidx_o,
    input  logic [IW-1:0]   cur_i,
    input  logic [XW-1:0]   thr_i,
    output logic            spike_o,
    output logic [IDXW-1:0] spike_idx_o
);
    localparam int INHW = $clog2(INH_STEPS + 2);

    typedef struct packed {
        logic            spike;
        logic [IDXW-1:0] idx;
    } spk_t;

    logic            busy, last, inh_act;
    logic [IDXW-1:0] idx, win;
    logic [XW-1:0]   x_rd, x_upd, x_wr;
    logic            held, fire;
    spk_t            o_d, o_q;

    lif_seq #(.N_NEUR(N_NEUR), .IDXW(IDXW)) u_seq (
        .clk(clk), .rst_n(rst_n), .step_i(step_i),
        .busy_o(busy), .idx_o(idx), .last_o(last)
    );

    lif_state_bank #(.N_NEUR(N_NEUR), .IDXW(IDXW), .XW(XW)) u_bank (
        .clk(clk), .rst_n(rst_n), .we_i(busy), .addr_i(idx),
        .wdata_i(x_wr), .rdata_o(x_rd)
    );

    lif_leak #(.XW(XW), .IW(IW), .SHIFT(LEAK_SHIFT)) u_leak (
        .x_i(x_rd), .cur_i(cur_i), .x_o(x_upd)
    );

    lif_inhibit #(.N_NEUR(N_NEUR), .IDXW(IDXW), .INH_STEPS(INH_STEPS), .INHW(INHW)) u_inh (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .fire_idx_i(idx),
        .step_end_i(last), .inh_o(inh_act), .win_o(win)
    );

    always_comb begin
        held = inh_act && (idx != win);
        fire = busy && !held && (x_upd >= thr_i);
        x_wr = (held || fire) ? '0 : x_upd;
        o_d.spike = fire;
        o_d.idx   = fire ? idx : o_q.idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign busy_o      = busy;
    assign nidx_o      = idx;
    assign spike_o     = o_q.spike;
    assign spike_idx_o = o_q.idx;
endmodule

// File: rtl/lif_layer_chk.sv
module lif_layer_chk #(
    parameter int N_NEUR = 8,
    parameter int IDXW   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            step_i,
    input logic            busy_o,
    input logic [IDXW-1:0] nidx_o,
    input logic            spike_o,
    input logic [IDXW-1:0] spike_idx_o
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(N_NEUR - 1);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (!busy_o && step_i) begin
            seen_q <= 1'b0;
        end else if (spike_o) begin
            seen_q <= 1'b1;
        end
    end

    assert_sweep_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && step_i) |=> (busy_o && nidx_o == '0));

    assert_sweep_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && nidx_o != LAST_IDX) |=> (busy_o && nidx_o == IDXW'($past(nidx_o) + 1'b1)));

    assert_sweep_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && nidx_o == LAST_IDX) |=> !busy_o);

    assert_spike_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spike_o |=> !spike_o);

    assert_spike_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spike_o |-> ($past(busy_o) && spike_idx_o == $past(nidx_o)));

    assert_one_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spike_o |-> !seen_q);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> !spike_o);
endmodule

bind lif_layer lif_layer_chk #(.N_NEUR(N_NEUR), .IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .busy_o(busy_o),
    .nidx_o(nidx_o), .spike_o(spike_o), .spike_idx_o(spike_idx_o)
);

// File: tb/test_lif_layer.sv
module test_lif_layer;
    localparam int N  = 8;
    localparam int IX = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_i = 1'b0;
    logic          busy_o, spike_o;
    logic [IX-1:0] nidx_o, spike_idx_o;
    logic [15:0]   cur_i, thr_i;
    logic [15:0]   cur_arr [N];
    logic [15:0]   thr_v = 16'd1000;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Reference state of the layer, built from the requirements.
    int xm [N];
    int inhm = 0, winm = 0;

    typedef struct packed {
        logic [N*16-1:0] cur;
        logic [15:0]     thr;
        logic [7:0]      nst;
    } row_t;

    // Currents are listed neuron 7 first, neuron 0 last.
    localparam row_t ROWS [9] = '{
        '{cur: {16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0},     thr: 16'd1000, nst: 8'd3},
        '{cur: {16'd0,16'd0,16'd300,16'd0,16'd0,16'd0,16'd0,16'd0},   thr: 16'd1000, nst: 8'd6},
        '{cur: {16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0},     thr: 16'd1000, nst: 8'd12},
        '{cur: {16'd0,16'd500,16'd0,16'd0,16'd0,16'd500,16'd0,16'd0}, thr: 16'd1000, nst: 8'd4},
        '{cur: {16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0},     thr: 16'd1000, nst: 8'd12},
        '{cur: {16'd0,16'd0,16'd0,16'd900,16'd0,16'd0,16'd200,16'd0}, thr: 16'd800,  nst: 8'd5},
        '{cur: {16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd200,16'd0},   thr: 16'd800,  nst: 8'd18},
        '{cur: {16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0,16'd0},     thr: 16'd1000, nst: 8'd12},
        '{cur: {16'd0,16'd0,16'd0,16'd0,16'd1000,16'd0,16'd0,16'd0},  thr: 16'd1993, nst: 8'd3}
    };

    assign cur_i = cur_arr[nidx_o];
    assign thr_i = thr_v;

    lif_layer i_lif_layer (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .busy_o(busy_o),
        .nidx_o(nidx_o), .cur_i(cur_i), .thr_i(thr_i),
        .spike_o(spike_o), .spike_idx_o(spike_idx_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One step of the reference: leak and add (R3), inclusive threshold (R4),
    // lowest index first (R5), inhibition window (R6), winner exempt (R7), saturation (R9).
    task automatic model_step(output int en, output int ei);
        en = 0;
        ei = -1;
        for (int i = 0; i < N; i++) begin
            if (inhm > 0 && i != winm) begin
                xm[i] = 0;
            end else begin
                int nx;
                nx = xm[i] - (xm[i] >>> 7) + int'(cur_arr[i]);
                if (nx > 65535) nx = 65535;
                if (nx >= int'(thr_v)) begin
                    xm[i] = 0;
                    en++;
                    ei = i;
                    winm = i;
                    inhm = 11;
                end else begin
                    xm[i] = nx;
                end
            end
        end
        if (inhm > 0) inhm--;
    endtask

    task automatic run_step(input bit extra, input string req, output int gn, output int gi);
        int en, ei;
        model_step(en, ei);
        gn = 0;
        gi = -1;
        @(negedge clk) step_i = 1'b1;
        @(negedge clk) step_i = 1'b0;
        chk(busy_o === 1'b1 && nidx_o == 0, "R2 sweep start", int'(nidx_o), 0);
        for (int k = 1; k <= 9; k++) begin
            step_i = (extra && k == 2);
            @(negedge clk);
            if (spike_o === 1'b1) begin
                gn++;
                gi = int'(spike_idx_o);
            end
            if (k <= 7) chk(busy_o === 1'b1 && int'(nidx_o) == k, "R2 sweep index", int'(nidx_o), k);
            if (k == 8) chk(busy_o === 1'b0, "R2 R8 sweep length", int'(busy_o), 0);
        end
        step_i = 1'b0;
        chk(gn == en, {req, " spike count"}, gn, en);
        if (en == 1) chk(gi == ei, {req, " spike index"}, gi, ei);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int gn, gi;
        for (int i = 0; i < N; i++) begin
            cur_arr[i] = 16'd0;
            xm[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: idle and quiet in reset and right after it
        chk(busy_o === 1'b0, "R1 busy after reset", int'(busy_o), 0);
        chk(spike_o === 1'b0, "R1 spike after reset", int'(spike_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o === 1'b0 && spike_o === 1'b0, "R1 idle after release", int'(spike_o), 0);
        // R1: zero states with zero current must not reach a threshold of 1
        thr_v = 16'd1;
        run_step(1'b0, "R1 zero state", gn, gi);
        chk(gn == 0, "R1 no spike from cleared state", gn, 0);

        // Table walk: R3 R4 R5 R6 R7 against the reference
        for (int r = 0; r < 9; r++) begin
            for (int i = 0; i < N; i++) cur_arr[i] = ROWS[r].cur[16*i +: 16];
            thr_v = ROWS[r].thr;
            for (int s = 0; s < int'(ROWS[r].nst); s++) begin
                run_step(1'b0, "R3 R4 R5 R6 R7 table", gn, gi);
            end
        end

        // R8: a second request during the sweep is ignored
        for (int i = 0; i < N; i++) cur_arr[i] = 16'd0;
        thr_v = 16'd1000;
        run_step(1'b1, "R8 request while busy", gn, gi);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(busy_o === 1'b0, "R8 no extra sweep", int'(busy_o), 0);
        end

        // R9: let the window lapse, then overflow neuron 0 on its second step
        for (int s = 0; s < 12; s++) run_step(1'b0, "R6 quiet", gn, gi);
        for (int i = 0; i < N; i++) xm[i] = 0;
        for (int s = 0; s < 3; s++) run_step(1'b0, "R3 drain", gn, gi);
        cur_arr[0] = 16'd40000;
        thr_v = 16'hFFFF;
        run_step(1'b0, "R9 first step", gn, gi);
        chk(gn == 0, "R9 below max", gn, 0);
        run_step(1'b0, "R9 second step", gn, gi);
        chk(gn == 1 && gi == 0, "R9 saturated state fires", gi, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule